// File: doc/BRIEF.md
# DVI Transmitter Register Init Sequencer

This block brings an external DVI transmitter into a working pixel-output configuration after power-up. Once reset is released it waits a programmable number of clock cycles, so that the transmitter can leave its own reset, and then issues a short ordered list of register writes. Each write is an (device address, register address, data) request handed to an external I2C master over a valid/ready handshake. After each write is accepted, the block waits for the master's completion response before it moves on. An error response stops the list and raises a sticky error flag. A clean completion of the last write raises a done flag.

The contents of the list depend on three static setting inputs. The first selects the pixel-clock range (above 65 MHz or not), which picks the PLL charge-pump, divider and filter values. The second enables RGB bypass, which changes the power-management value and appends a DAC-enable write. The third selects the sync polarity standard, which sets the input-format value. A restart input replays the whole list from the first register once the block is idle in its done or error state.

The controller has five states. ST_HOLDOFF goes to ST_ISSUE when the hold-off timer expires. ST_ISSUE goes to ST_AWAIT when the request is accepted. ST_AWAIT goes to ST_FAIL on an error response, to ST_DONE on a good response to the last write, and back to ST_ISSUE with the next index on any other good response. ST_DONE and ST_FAIL go to ST_ISSUE at index 0 on restart.

Top module: `dvi_cfg_seq`

## Requirements
- R1: While rst_n is low, req_valid, done and error are 0. After reset is released, req_valid first reads 1 after exactly HOLDOFF_CYCLES+1 rising clock edges.
- R2: Every request carries req_dev = DEV_ADDR. The register addresses come in this order: 0x49, 0x33, 0x34, 0x36, 0x1F, then 0x21. The 0x21 write is issued only when bypass_en = 1, so there are 5 writes without bypass and 6 with it.
- R3: The data for register 0x49 is 0xC0 when bypass_en = 0 and 0xD0 when bypass_en = 1. The data for register 0x21 is 0x09.
- R4: When hi_clk = 0, registers 0x33, 0x34 and 0x36 receive 0x08, 0x16 and 0x60. When hi_clk = 1, they receive 0x06, 0x26 and 0xA0.
- R5: Register 0x1F receives 0x80 when sync_cvt = 0 and 0x90 when sync_cvt = 1.
- R6: While req_valid = 1 and req_ready = 0, req_valid, req_reg and req_data keep their values in the next cycle. In the cycle after req_ready is sampled high, req_valid is 0.
- R7: After a request is accepted, req_valid stays 0 until rsp_valid = 1 with rsp_err = 0 is sampled. If more writes remain, req_valid is 1 in the next cycle.
- R8: A response with rsp_valid = 1 and rsp_err = 1 sets error in the next cycle. Error then stays 1, no further request is raised and done stays 0, until restart.
- R9: A response with rsp_valid = 1 and rsp_err = 0 to the last write sets done in the next cycle. Done stays 1 until restart.
- R10: When restart = 1 is sampled in the done or error state, done and error clear in the next cycle and req_valid rises with register 0x49, with no hold-off. A restart sampled in any other state has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Replay request, honoured only when done or error |
| hi_clk | input | 1 | 1 = pixel clock above 65 MHz (static) |
| bypass_en | input | 1 | 1 = RGB bypass on, DAC write appended (static) |
| sync_cvt | input | 1 | 1 = CVT sync polarity, 0 = SMT (static) |
| req_valid | output | 1 | Write request valid |
| req_ready | input | 1 | I2C master accepts the request |
| req_dev | output | 7 | I2C device address |
| req_reg | output | 8 | Transmitter register address |
| req_data | output | 8 | Register data |
| rsp_valid | input | 1 | Completion pulse for the accepted write |
| rsp_err | input | 1 | Completion carried an error |
| done | output | 1 | Whole list written without error |
| error | output | 1 | Sticky error, list stopped |

## Verification
The in-line properties check, on every cycle, the parts of the behaviour that are local in time. They cover the hold-off counter stepping down, the stability of a stalled request, 0x49 being the first write after hold-off or restart, the DAC write appearing only with bypass, the stickiness of done and error, and done rising only after a good response. Only the bench's scenarios can show the full ordered list and its data values for all eight setting combinations. The same holds for the exact hold-off length, for restart being ignored mid-list, and for an error at a middle or final write stopping the list.

// File: rtl/dvi_cfg_pkg.sv
package dvi_cfg_pkg;

    localparam int NUM_STEPS = 6;
    localparam int IDX_W     = $clog2(NUM_STEPS);

    typedef logic [IDX_W-1:0] step_idx_t;

    // transmitter register addresses, in issue order
    localparam logic [7:0] REG_POWER    = 8'h49;
    localparam logic [7:0] REG_PLL_CP   = 8'h33;
    localparam logic [7:0] REG_PLL_DIV  = 8'h34;
    localparam logic [7:0] REG_PLL_FLT  = 8'h36;
    localparam logic [7:0] REG_IN_FMT   = 8'h1F;
    localparam logic [7:0] REG_DAC      = 8'h21;

    localparam int LAST_PLAIN  = 4;   // index of last write without bypass
    localparam int LAST_BYPASS = 5;   // index of last write with bypass

    typedef enum logic [2:0] {
        ST_HOLDOFF,
        ST_ISSUE,
        ST_AWAIT,
        ST_DONE,
        ST_FAIL
    } seq_state_t;

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] data;
    } reg_write_t;

endpackage

// File: rtl/dvi_cfg_holdoff.sv
module dvi_cfg_holdoff #(
    parameter int unsigned CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int unsigned CNT_W = (CYCLES < 1) ? 1 : $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= LOAD;
        end else if (run && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // R1: the wait steps down by one per cycle while it runs
    p_countdown_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !expired) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/dvi_cfg_table.sv
module dvi_cfg_table
    import dvi_cfg_pkg::*;
(
    input  step_idx_t  idx,
    input  logic       hi_clk,
    input  logic       bypass_en,
    input  logic       sync_cvt,
    output reg_write_t wr,
    output logic       last
);

    // values chosen by the static settings
    logic [7:0] pwr_val, cp_val, div_val, flt_val, fmt_val;

    always_comb begin
        pwr_val = bypass_en ? 8'hD0 : 8'hC0;
        cp_val  = hi_clk    ? 8'h06 : 8'h08;
        div_val = hi_clk    ? 8'h26 : 8'h16;
        flt_val = hi_clk    ? 8'hA0 : 8'h60;
        fmt_val = sync_cvt  ? 8'h90 : 8'h80;
    end

    always_comb begin
        wr = '{addr: 8'h00, data: 8'h00};
        case (idx)
            step_idx_t'(0): wr = '{addr: REG_POWER,   data: pwr_val};
            step_idx_t'(1): wr = '{addr: REG_PLL_CP,  data: cp_val};
            step_idx_t'(2): wr = '{addr: REG_PLL_DIV, data: div_val};
            step_idx_t'(3): wr = '{addr: REG_PLL_FLT, data: flt_val};
            step_idx_t'(4): wr = '{addr: REG_IN_FMT,  data: fmt_val};
            step_idx_t'(5): wr = '{addr: REG_DAC,     data: 8'h09};
            default:        wr = '{addr: 8'h00,       data: 8'h00};
        endcase
    end

    assign last = bypass_en ? (idx == step_idx_t'(LAST_BYPASS))
                            : (idx == step_idx_t'(LAST_PLAIN));

endmodule

// File: rtl/dvi_cfg_seq.sv
module dvi_cfg_seq
    import dvi_cfg_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR       = 7'h76,
    parameter int unsigned HOLDOFF_CYCLES = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       hi_clk,
    input  logic       bypass_en,
    input  logic       sync_cvt,
    output logic       req_valid,
    input  logic       req_ready,
    output logic [6:0] req_dev,
    output logic [7:0] req_reg,
    output logic [7:0] req_data,
    input  logic       rsp_valid,
    input  logic       rsp_err,
    output logic       done,
    output logic       error
);

    seq_state_t state, state_nxt;
    step_idx_t  idx, idx_nxt;
    reg_write_t cur_wr;
    logic       cur_last;
    logic       hold_run, hold_expired;

    dvi_cfg_holdoff #(
        .CYCLES (HOLDOFF_CYCLES)
    ) u_holdoff (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (hold_run),
        .expired (hold_expired)
    );

    dvi_cfg_table u_table (
        .idx       (idx),
        .hi_clk    (hi_clk),
        .bypass_en (bypass_en),
        .sync_cvt  (sync_cvt),
        .wr        (cur_wr),
        .last      (cur_last)
    );

    // next state
    always_comb begin
        state_nxt = state;
        idx_nxt   = idx;
        unique case (state)
            ST_HOLDOFF: begin
                if (hold_expired) state_nxt = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (req_ready) state_nxt = ST_AWAIT;
            end
            ST_AWAIT: begin
                if (rsp_valid) begin
                    if (rsp_err) begin
                        state_nxt = ST_FAIL;
                    end else if (cur_last) begin
                        state_nxt = ST_DONE;
                    end else begin
                        state_nxt = ST_ISSUE;
                        idx_nxt   = idx + 1'b1;
                    end
                end
            end
            ST_DONE, ST_FAIL: begin
                if (restart) begin
                    state_nxt = ST_ISSUE;
                    idx_nxt   = '0;
                end
            end
            default: state_nxt = ST_HOLDOFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HOLDOFF;
            idx   <= '0;
        end else begin
            state <= state_nxt;
            idx   <= idx_nxt;
        end
    end

    // outputs
    always_comb begin
        hold_run  = (state == ST_HOLDOFF);
        req_valid = (state == ST_ISSUE);
        done      = (state == ST_DONE);
        error     = (state == ST_FAIL);
        req_dev   = DEV_ADDR;
        req_reg   = cur_wr.addr;
        req_data  = cur_wr.data;
    end

    // R6: a stalled request holds still
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_reg) && $stable(req_data)));

    // R2: the list always opens with the power register
    p_first_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(state != ST_ISSUE && state != ST_AWAIT)) |-> (req_reg == REG_POWER));

    // R2: DAC write only with bypass
    p_dac_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_reg == REG_DAC) |-> bypass_en);

    // R8: error is sticky and silences requests
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !restart) |=> (error && !req_valid && !done));

    // R9: done is sticky
    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !restart) |=> done);

    // R9: done rises only after a good response
    p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(rsp_valid && !rsp_err));

endmodule

// File: tb/test_dvi_cfg_seq.sv
`timescale 1ns/1ps
module test_dvi_cfg_seq;

    localparam int         HOLD = 12;
    localparam logic [6:0] DEV  = 7'h76;

    // {5'b0, hi_clk, bypass_en, sync_cvt, pwr, cp, div, flt, fmt}
    localparam logic [47:0] VEC [8] = '{
        48'h00_C0_08_16_60_80,
        48'h01_C0_08_16_60_90,
        48'h02_D0_08_16_60_80,
        48'h03_D0_08_16_60_90,
        48'h04_C0_06_26_A0_80,
        48'h05_C0_06_26_A0_90,
        48'h06_D0_06_26_A0_80,
        48'h07_D0_06_26_A0_90
    };

    logic clk = 0, rst_n = 0, restart = 0;
    logic hi_clk = 0, bypass_en = 0, sync_cvt = 0;
    logic req_valid, req_ready = 0, rsp_valid = 0, rsp_err = 0;
    logic [6:0] req_dev;
    logic [7:0] req_reg, req_data;
    logic done, error;

    int tests = 0, fails = 0, cyc = 0;

    always #2.5 clk = ~clk;

    dvi_cfg_seq #(.DEV_ADDR(DEV), .HOLDOFF_CYCLES(HOLD)) i_dvi_cfg_seq (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .hi_clk(hi_clk), .bypass_en(bypass_en), .sync_cvt(sync_cvt),
        .req_valid(req_valid), .req_ready(req_ready), .req_dev(req_dev),
        .req_reg(req_reg), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .done(done), .error(error)
    );

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                fails++;
                tests++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_reg(input int k);
        case (k)
            0: return 8'h49;
            1: return 8'h33;
            2: return 8'h34;
            3: return 8'h36;
            4: return 8'h1F;
            default: return 8'h21;
        endcase
    endfunction

    function automatic logic [7:0] exp_data(input logic [47:0] v, input int k);
        case (k)
            0: return v[39:32];
            1: return v[31:24];
            2: return v[23:16];
            3: return v[15:8];
            4: return v[7:0];
            default: return 8'h09;
        endcase
    endfunction

    function automatic string data_tag(input int k);
        if (k == 0 || k == 5) return "R3";
        if (k == 4) return "R5";
        return "R4";
    endfunction

    task automatic apply_cfg(input logic [47:0] v);
        hi_clk    = v[42];
        bypass_en = v[41];
        sync_cvt  = v[40];
    endtask

    // act as the I2C master for one pass of the list
    task automatic serve(input logic [47:0] v, input int err_at, input bit probe);
        int n;
        n = v[41] ? 6 : 5;
        for (int k = 0; k < n; k++) begin
            int t;
            bit stable_ok, quiet_ok;
            logic [7:0] r0, d0;
            t = 0;
            while (!req_valid && t < 50) begin
                @(negedge clk);
                t++;
            end
            chk(req_valid && req_reg == exp_reg(k) && req_dev == DEV, "R2", "register order",
                {req_valid, 7'(req_dev), 8'(req_reg)}, {1'b1, DEV, exp_reg(k)});
            chk(req_data == exp_data(v, k), data_tag(k), "register data", req_data, exp_data(v, k));
            if (probe && k == 2)
                chk(req_reg == 8'h34, "R10", "restart mid-list ignored", req_reg, 8'h34);
            r0 = req_reg;
            d0 = req_data;
            stable_ok = 1;
            for (int s = 0; s < k % 3; s++) begin
                @(negedge clk);
                if (!(req_valid && req_reg == r0 && req_data == d0)) stable_ok = 0;
            end
            chk(stable_ok, "R6", "stalled request stable", {31'd0, stable_ok}, 1);
            req_ready = 1;
            @(negedge clk);
            req_ready = 0;
            chk(!req_valid, "R6", "valid drops after accept", req_valid, 0);
            quiet_ok = 1;
            for (int j = 0; j < 1 + k % 2; j++) begin
                if (probe && k == 1 && j == 0) restart = 1;
                @(negedge clk);
                restart = 0;
                if (req_valid) quiet_ok = 0;
            end
            chk(quiet_ok, "R7", "no request before response", {31'd0, quiet_ok}, 1);
            rsp_valid = 1;
            rsp_err   = (k == err_at);
            @(negedge clk);
            rsp_valid = 0;
            rsp_err   = 0;
            if (k == err_at) begin
                bit hold_ok;
                chk(error && !done && !req_valid, "R8", "error raised",
                    {29'd0, error, done, req_valid}, 3'b100);
                hold_ok = 1;
                for (int j = 0; j < 5; j++) begin
                    @(negedge clk);
                    if (!error || done || req_valid) hold_ok = 0;
                end
                chk(hold_ok, "R8", "error sticky, list stopped", {31'd0, hold_ok}, 1);
                return;
            end
            if (k < n - 1)
                chk(req_valid, "R7", "next request after good response", req_valid, 1);
        end
        chk(done && !error, "R9", "done after last write", {30'd0, done, error}, 2'b10);
        repeat (3) @(negedge clk);
        chk(done && !req_valid, "R9", "done sticky", {30'd0, done, req_valid}, 2'b10);
    endtask

    task automatic do_restart(input logic [47:0] v);
        apply_cfg(v);
        @(negedge clk);
        restart = 1;
        @(negedge clk);
        restart = 0;
        chk(!done && !error && req_valid && req_reg == 8'h49, "R10", "restart replays list",
            {21'd0, done, error, req_valid, req_reg}, {3'b001, 8'h49});
    endtask

    task automatic measure_holdoff();
        int n;
        n = 0;
        rst_n = 1;
        while (n < 100) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (req_valid) break;
        end
        chk(n == HOLD + 1, "R1", "hold-off length", n, HOLD + 1);
    endtask

    initial begin
        apply_cfg(VEC[0]);
        repeat (3) @(negedge clk);
        chk(!req_valid && !done && !error, "R1", "reset state",
            {29'd0, req_valid, done, error}, 0);
        measure_holdoff();

        // vector table: every setting combination
        serve(VEC[0], -1, 0);
        for (int c = 1; c < 8; c++) begin
            do_restart(VEC[c]);
            serve(VEC[c], -1, c == 2);
        end

        // error in the middle of the list
        do_restart(VEC[5]);
        serve(VEC[5], 2, 0);
        do_restart(VEC[6]);
        serve(VEC[6], -1, 0);

        // error on the final write
        do_restart(VEC[7]);
        serve(VEC[7], 5, 0);
        do_restart(VEC[1]);
        serve(VEC[1], -1, 0);

        // reset in the middle of a list restarts the hold-off
        do_restart(VEC[4]);
        rst_n = 0;
        @(negedge clk);
        chk(!req_valid && !done && !error, "R1", "reset mid-list",
            {29'd0, req_valid, done, error}, 0);
        measure_holdoff();
        serve(VEC[4], -1, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule